// File: doc/BRIEF.md
# Interrupt Acknowledge and Nesting Tracker

This block is the per-CPU half of an interrupt controller that deals with the acknowledge and completion handshakes. An arbiter elsewhere offers the best pending interrupt ID and its priority. When software reads the acknowledge register, the tracker decides whether that interrupt may preempt the one now running. If it may, the tracker returns the ID, makes it the running interrupt and asks the arbiter to drop its pending state. If it may not, the tracker returns the spurious code 1023.

Interrupts that have been preempted are not kept on a stack. Each source has one predecessor slot in a small link memory. The running interrupt points back to the interrupt it displaced, that one points to the one before it, and the chain ends with 1023. Completing the running interrupt restores its predecessor in one cycle. Completing any other ID starts a walk along the chain, one link per clock, and splices that ID out. During the walk a busy flag holds off new requests.

Top module: `ack_nest_tracker`

## Requirements
- R1: An acknowledge strobe returns ID 1023 and changes no state, and raises no pending-clear request, when the offered ID is 1023, when the offered ID is not below the source count, or when the offered priority is not strictly lower than the running priority.
- R2: A successful acknowledge returns the offered ID and makes it the running interrupt. The previous running interrupt is recorded as its predecessor.
- R3: A successful acknowledge raises a pending-clear request for that ID. The CPU mask has every bit set when the source uses the one-of-N model (`pend_all_cpu_i` = 1). Otherwise only bit `CPU_IDX` is set.
- R4: The running priority is the priority captured when the running interrupt was acknowledged, zero-extended to 9 bits. It is 0x100 while the running ID is 1023.
- R5: A completion strobe has no effect while the running ID is 1023, and none when its ID is not below the source count.
- R6: Completing the running ID restores its recorded predecessor as the running interrupt, together with the predecessor's captured priority, one cycle after the strobe.
- R7: Completing an ID other than the running one leaves the running interrupt unchanged. If the ID is in the chain, the node linking to it takes over its predecessor. If it is absent, no link changes.
- R8: After reset the running ID is 1023, the running priority is 0x100, and busy, acknowledge-valid and pending-clear are all low.
- R9: A chain walk advances one link per cycle. `busy_o` is high for exactly as many cycles as links visited. Acknowledge and completion strobes that arrive while `busy_o` is high are ignored.
- R10: When acknowledge and completion strobes arrive in the same idle cycle, the completion is taken and the acknowledge is ignored (no `ack_valid_o`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_id_i | input | 10 | Best pending ID offered by the arbiter (1023 = none) |
| pend_prio_i | input | PRIO_W | Priority of the offered ID (lower is more urgent) |
| pend_all_cpu_i | input | 1 | Offered source uses the one-of-N model |
| ack_req_i | input | 1 | Acknowledge read strobe |
| eoi_req_i | input | 1 | Completion write strobe |
| eoi_id_i | input | 10 | ID being completed |
| busy_o | output | 1 | Chain walk in progress; strobes ignored |
| ack_valid_o | output | 1 | Acknowledge result valid (one cycle after the strobe) |
| ack_id_o | output | 10 | Acknowledge result ID |
| run_id_o | output | 10 | Running interrupt ID |
| run_prio_o | output | PRIO_W+1 | Running priority (0x100 when idle) |
| clr_req_o | output | 1 | Pending-clear request pulse |
| clr_id_o | output | 10 | ID whose pending state is to be cleared |
| clr_mask_o | output | NCPU | CPUs whose pending bit is to be cleared |

## Verification
A corrupted link usually stays hidden until the running interrupt is completed. At that point the wrong predecessor, or its priority, shows on `run_id_o` and `run_prio_o` in the cycle after the strobe. The bench therefore builds a three-deep chain, splices the middle and the bottom entries out, and unwinds the rest. This exposes any bad splice within two completions. An error in the walk length is visible at once as a wrong count of `busy_o` cycles. An error in the stall logic is visible as an `ack_valid_o` pulse during the walk.

// File: rtl/tracker_pkg.sv
package tracker_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] NO_IRQ = '1;
endpackage

// File: rtl/link_store.sv
module link_store
    import tracker_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int PRIO_W = 8,
    parameter int N_LRD  = 2,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            link_we,
    input  logic                            prio_we,
    input  logic [IDX_W-1:0]                waddr,
    input  logic [ID_W-1:0]                 wlink,
    input  logic [PRIO_W-1:0]               wprio,
    input  logic [N_LRD-1:0][IDX_W-1:0]     lrd_addr,
    output logic [N_LRD-1:0][ID_W-1:0]      lrd_data,
    input  logic [IDX_W-1:0]                prd_addr,
    output logic [PRIO_W-1:0]               prd_data
);
    logic [ID_W-1:0]   link_q [NSRC];
    logic [PRIO_W-1:0] prio_q [NSRC];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                link_q[i] <= NO_IRQ;
                prio_q[i] <= '0;
            end
        end else begin
            if (link_we) link_q[waddr] <= wlink;
            if (prio_we) prio_q[waddr] <= wprio;
        end
    end

    for (genvar p = 0; p < N_LRD; p++) begin : g_lrd
        assign lrd_data[p] = (int'(lrd_addr[p]) < NSRC) ? link_q[lrd_addr[p]] : NO_IRQ;
    end

    assign prd_data = (int'(prd_addr) < NSRC) ? prio_q[prd_addr] : '0;
endmodule

// File: rtl/clr_mask_gen.sv
module clr_mask_gen #(
    parameter int NCPU    = 4,
    parameter int CPU_IDX = 0
) (
    input  logic            all_cpu,
    output logic [NCPU-1:0] mask
);
    for (genvar c = 0; c < NCPU; c++) begin : g_bit
        if (c == CPU_IDX) begin : g_own
            assign mask[c] = 1'b1;
        end else begin : g_other
            assign mask[c] = all_cpu;
        end
    end
endmodule

// File: rtl/ack_nest_tracker.sv
module ack_nest_tracker
    import tracker_pkg::*;
#(
    parameter int NSRC    = 64,
    parameter int PRIO_W  = 8,
    parameter int NCPU    = 4,
    parameter int CPU_IDX = 0,
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int RP_W   = PRIO_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   pend_id_i,
    input  logic [PRIO_W-1:0] pend_prio_i,
    input  logic              pend_all_cpu_i,
    input  logic              ack_req_i,
    input  logic              eoi_req_i,
    input  logic [ID_W-1:0]   eoi_id_i,
    output logic              busy_o,
    output logic              ack_valid_o,
    output logic [ID_W-1:0]   ack_id_o,
    output logic [ID_W-1:0]   run_id_o,
    output logic [RP_W-1:0]   run_prio_o,
    output logic              clr_req_o,
    output logic [ID_W-1:0]   clr_id_o,
    output logic [NCPU-1:0]   clr_mask_o
);
    localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1) << PRIO_W;

    typedef struct packed {
        logic [ID_W-1:0] run_id;
        logic [RP_W-1:0] run_prio;
        logic            busy;
        logic [ID_W-1:0] walk_node;
        logic [ID_W-1:0] walk_tgt;
        logic            ack_vld;
        logic [ID_W-1:0] ack_id;
        logic            clr_req;
        logic [ID_W-1:0] clr_id;
        logic [NCPU-1:0] clr_mask;
    } state_t;

    state_t st_d, st_q;

    function automatic logic in_range(input logic [ID_W-1:0] id);
        return int'(id) < NSRC;
    endfunction

    function automatic logic [IDX_W-1:0] to_idx(input logic [ID_W-1:0] id);
        return IDX_W'(id);
    endfunction

    // link memory ports
    logic                        link_we_d, prio_we_d;
    logic [IDX_W-1:0]            waddr_d;
    logic [ID_W-1:0]             wlink_d;
    logic [1:0][IDX_W-1:0]       lrd_addr;
    logic [1:0][ID_W-1:0]        lrd_data;
    logic [PRIO_W-1:0]           prd_data;
    logic [NCPU-1:0]             own_mask;

    // port 0: predecessor of the running ID, or link of the walk node
    assign lrd_addr[0] = st_q.busy ? to_idx(st_q.walk_node) : to_idx(st_q.run_id);
    // port 1: predecessor of the ID being spliced out
    assign lrd_addr[1] = to_idx(st_q.walk_tgt);

    link_store #(
        .NSRC   (NSRC),
        .PRIO_W (PRIO_W),
        .N_LRD  (2)
    ) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_we  (link_we_d),
        .prio_we  (prio_we_d),
        .waddr    (waddr_d),
        .wlink    (wlink_d),
        .wprio    (pend_prio_i),
        .lrd_addr (lrd_addr),
        .lrd_data (lrd_data),
        .prd_addr (to_idx(lrd_data[0])),
        .prd_data (prd_data)
    );

    clr_mask_gen #(
        .NCPU    (NCPU),
        .CPU_IDX (CPU_IDX)
    ) u_mask (
        .all_cpu (pend_all_cpu_i),
        .mask    (own_mask)
    );

    logic eoi_go, ack_go, ack_hit;

    always_comb begin
        st_d          = st_q;
        st_d.ack_vld  = 1'b0;
        st_d.ack_id   = NO_IRQ;
        st_d.clr_req  = 1'b0;
        link_we_d     = 1'b0;
        prio_we_d     = 1'b0;
        waddr_d       = '0;
        wlink_d       = NO_IRQ;

        eoi_go  = eoi_req_i && !st_q.busy;
        ack_go  = ack_req_i && !st_q.busy && !eoi_req_i;
        ack_hit = (pend_id_i != NO_IRQ) && in_range(pend_id_i)
                  && ({1'b0, pend_prio_i} < st_q.run_prio);

        if (st_q.busy) begin
            // one link per cycle
            if (lrd_data[0] == NO_IRQ) begin
                st_d.busy = 1'b0;
            end else if (lrd_data[0] == st_q.walk_tgt) begin
                link_we_d = 1'b1;
                waddr_d   = to_idx(st_q.walk_node);
                wlink_d   = lrd_data[1];
                st_d.busy = 1'b0;
            end else begin
                st_d.walk_node = lrd_data[0];
            end
        end else if (eoi_go) begin
            if (st_q.run_id != NO_IRQ && in_range(eoi_id_i)) begin
                if (eoi_id_i == st_q.run_id) begin
                    st_d.run_id   = lrd_data[0];
                    st_d.run_prio = (lrd_data[0] == NO_IRQ) ? IDLE_PRIO
                                                            : {1'b0, prd_data};
                end else begin
                    st_d.busy      = 1'b1;
                    st_d.walk_node = st_q.run_id;
                    st_d.walk_tgt  = eoi_id_i;
                end
            end
        end else if (ack_go) begin
            st_d.ack_vld = 1'b1;
            if (ack_hit) begin
                st_d.ack_id   = pend_id_i;
                link_we_d     = 1'b1;
                prio_we_d     = 1'b1;
                waddr_d       = to_idx(pend_id_i);
                wlink_d       = st_q.run_id;
                st_d.run_id   = pend_id_i;
                st_d.run_prio = {1'b0, pend_prio_i};
                st_d.clr_req  = 1'b1;
                st_d.clr_id   = pend_id_i;
                st_d.clr_mask = own_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run_id: NO_IRQ, run_prio: IDLE_PRIO, busy: 1'b0,
                      walk_node: NO_IRQ, walk_tgt: NO_IRQ, ack_vld: 1'b0,
                      ack_id: NO_IRQ, clr_req: 1'b0, clr_id: NO_IRQ,
                      clr_mask: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign ack_valid_o = st_q.ack_vld;
    assign ack_id_o    = st_q.ack_id;
    assign run_id_o    = st_q.run_id;
    assign run_prio_o  = st_q.run_prio;
    assign clr_req_o   = st_q.clr_req;
    assign clr_id_o    = st_q.clr_id;
    assign clr_mask_o  = st_q.clr_mask;
endmodule

// File: rtl/ack_nest_checker.sv
module ack_nest_checker #(
    parameter int ID_W = 10,
    parameter int RP_W = 9,
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ack_req_i,
    input logic            eoi_req_i,
    input logic            busy_o,
    input logic            ack_valid_o,
    input logic [ID_W-1:0] ack_id_o,
    input logic [ID_W-1:0] run_id_o,
    input logic [RP_W-1:0] run_prio_o,
    input logic            clr_req_o,
    input logic [ID_W-1:0] clr_id_o,
    input logic [NCPU-1:0] clr_mask_o
);
    localparam logic [ID_W-1:0] NONE = '1;

    assert_spurious_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && ack_id_o == NONE) |-> ($stable(run_id_o) && !clr_req_o));

    assert_ack_takes_over_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && ack_id_o != NONE) |-> (run_id_o == ack_id_o && clr_req_o
                                               && clr_id_o == ack_id_o));

    assert_clr_mask_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_o |-> ($countones(clr_mask_o) == 1 || clr_mask_o == '1));

    assert_idle_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id_o == NONE) |-> (run_prio_o == RP_W'(1) << (RP_W - 1)));

    assert_eoi_idle_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req_i && !busy_o && run_id_o == NONE) |=> (run_id_o == NONE && !busy_o));

    assert_walk_keeps_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(run_id_o));

    assert_stall_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ack_req_i) |=> !ack_valid_o);

    assert_eoi_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req_i && ack_req_i) |=> !ack_valid_o);
endmodule

bind ack_nest_tracker ack_nest_checker #(
    .ID_W (tracker_pkg::ID_W),
    .RP_W (RP_W),
    .NCPU (NCPU)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req_i   (ack_req_i),
    .eoi_req_i   (eoi_req_i),
    .busy_o      (busy_o),
    .ack_valid_o (ack_valid_o),
    .ack_id_o    (ack_id_o),
    .run_id_o    (run_id_o),
    .run_prio_o  (run_prio_o),
    .clr_req_o   (clr_req_o),
    .clr_id_o    (clr_id_o),
    .clr_mask_o  (clr_mask_o)
);

// File: tb/tb_ack_nest_tracker.sv
module tb_ack_nest_tracker;
    localparam int NSRC = 64;
    localparam int NCPU = 4;
    localparam int CPU  = 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] pend_id_i = 10'h3FF;
    logic [7:0] pend_prio_i = 8'h00;
    logic       pend_all_cpu_i = 1'b0;
    logic       ack_req_i = 1'b0;
    logic       eoi_req_i = 1'b0;
    logic [9:0] eoi_id_i = 10'h000;
    logic       busy_o, ack_valid_o, clr_req_o;
    logic [9:0] ack_id_o, run_id_o, clr_id_o;
    logic [8:0] run_prio_o;
    logic [NCPU-1:0] clr_mask_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ack_nest_tracker #(.NSRC(NSRC), .PRIO_W(8), .NCPU(NCPU), .CPU_IDX(CPU)) dut (
        .clk(clk), .rst_n(rst_n), .pend_id_i(pend_id_i), .pend_prio_i(pend_prio_i),
        .pend_all_cpu_i(pend_all_cpu_i), .ack_req_i(ack_req_i), .eoi_req_i(eoi_req_i),
        .eoi_id_i(eoi_id_i), .busy_o(busy_o), .ack_valid_o(ack_valid_o),
        .ack_id_o(ack_id_o), .run_id_o(run_id_o), .run_prio_o(run_prio_o),
        .clr_req_o(clr_req_o), .clr_id_o(clr_id_o), .clr_mask_o(clr_mask_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_run(input string req, input logic [9:0] id, input logic [8:0] pr);
        chk(req, "run_id", 32'(run_id_o), 32'(id));
        chk(req, "run_prio", 32'(run_prio_o), 32'(pr));
    endtask

    // one acknowledge strobe; result sampled one cycle later
    task automatic t_ack(input string req, input logic [9:0] id, input logic [7:0] pr,
                         input bit all, input logic [9:0] exp_id,
                         input logic [NCPU-1:0] exp_mask);
        @(negedge clk);
        pend_id_i = id; pend_prio_i = pr; pend_all_cpu_i = all; ack_req_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack_req_i = 1'b0;
        chk(req, "ack_valid", 32'(ack_valid_o), 32'd1);
        chk(req, "ack_id", 32'(ack_id_o), 32'(exp_id));
        chk(req, "clr_req", 32'(clr_req_o), 32'(exp_id != 10'h3FF));
        if (exp_id != 10'h3FF) begin
            chk(req, "clr_id", 32'(clr_id_o), 32'(exp_id));
            chk(req, "clr_mask", 32'(clr_mask_o), 32'(exp_mask));
        end
    endtask

    // one completion strobe; counts busy cycles; optionally strobes ack during busy
    task automatic t_eoi(input string req, input logic [9:0] id,
                         input int exp_busy, input bit probe);
        int n = 0;
        @(negedge clk);
        eoi_id_i = id; eoi_req_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        eoi_req_i = 1'b0;
        while (busy_o && n < 50) begin
            n++;
            if (probe) begin
                ack_req_i = 1'b1; pend_id_i = 10'd20; pend_prio_i = 8'h01;
                // repeat completion strobe too: must be ignored
                eoi_req_i = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            ack_req_i = 1'b0; eoi_req_i = 1'b0;
            if (probe) chk("R9", "ack_valid during walk", 32'(ack_valid_o), 32'd0);
        end
        chk(req, "busy cycles", 32'(n), 32'(exp_busy));
    endtask

    task automatic t_reset;
        chk("R8", "busy", 32'(busy_o), 32'd0);
        chk("R8", "ack_valid", 32'(ack_valid_o), 32'd0);
        chk("R8", "clr_req", 32'(clr_req_o), 32'd0);
        chk_run("R8", 10'h3FF, 9'h100);
    endtask

    task automatic t_build_chain;
        t_ack("R1", 10'h3FF, 8'h10, 1'b0, 10'h3FF, '0);           // nothing offered
        chk_run("R1", 10'h3FF, 9'h100);
        t_ack("R1", 10'd100, 8'h10, 1'b0, 10'h3FF, '0);           // beyond source count
        t_ack("R2", 10'd5, 8'h80, 1'b0, 10'd5, 4'b0010);          // R3 own CPU only
        chk_run("R4", 10'd5, 9'h080);
        t_ack("R1", 10'd6, 8'h80, 1'b0, 10'h3FF, '0);             // equal priority refused
        chk_run("R1", 10'd5, 9'h080);
        t_ack("R3", 10'd9, 8'h40, 1'b1, 10'd9, 4'b1111);          // one-of-N: all CPUs
        chk_run("R2", 10'd9, 9'h040);
        t_ack("R2", 10'd12, 8'h10, 1'b0, 10'd12, 4'b0010);
        chk_run("R4", 10'd12, 9'h010);
    endtask

    task automatic t_splice;
        // chain 12 -> 9 -> 5 -> end
        t_eoi("R7", 10'd30, 3, 1'b1);                             // absent ID: full walk
        chk_run("R7", 10'd12, 9'h010);
        t_eoi("R9", 10'd5, 2, 1'b0);                              // splice bottom entry
        chk_run("R7", 10'd12, 9'h010);
        t_eoi("R6", 10'd12, 0, 1'b0);
        chk_run("R6", 10'd9, 9'h040);
        t_eoi("R6", 10'd9, 0, 1'b0);                              // 5 must be skipped
        chk_run("R7", 10'h3FF, 9'h100);
    endtask

    task automatic t_idle_eoi;
        t_eoi("R5", 10'd7, 0, 1'b0);
        chk_run("R5", 10'h3FF, 9'h100);
        t_ack("R4", 10'd3, 8'hFF, 1'b0, 10'd3, 4'b0010);
        chk_run("R4", 10'd3, 9'h0FF);
        t_eoi("R5", 10'd70, 0, 1'b0);                             // out of range ID
        chk_run("R5", 10'd3, 9'h0FF);
    endtask

    task automatic t_collide;
        // second chain 3 -> end, then middle splice with a deeper chain
        @(negedge clk);
        eoi_id_i = 10'd3; eoi_req_i = 1'b1;
        ack_req_i = 1'b1; pend_id_i = 10'd4; pend_prio_i = 8'h01;
        @(posedge clk);
        @(negedge clk);
        eoi_req_i = 1'b0; ack_req_i = 1'b0;
        chk("R10", "ack_valid", 32'(ack_valid_o), 32'd0);
        chk_run("R10", 10'h3FF, 9'h100);
        t_ack("R2", 10'd1, 8'h90, 1'b0, 10'd1, 4'b0010);
        t_ack("R2", 10'd2, 8'h50, 1'b0, 10'd2, 4'b0010);
        t_ack("R2", 10'd63, 8'h20, 1'b0, 10'd63, 4'b0010);
        t_eoi("R7", 10'd2, 1, 1'b0);                              // splice middle
        chk_run("R7", 10'd63, 9'h020);
        t_eoi("R6", 10'd63, 0, 1'b0);
        chk_run("R6", 10'd1, 9'h090);
        t_eoi("R6", 10'd1, 0, 1'b0);
        chk_run("R6", 10'h3FF, 9'h100);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_build_chain();
        t_splice();
        t_idle_eoi();
        t_collide();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule